// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds behind a small 16-bit register bus. A prescaler divides the reference clock by a programmable 32-bit rate word, normally set to the reference frequency in Hz, and produces one single-cycle second tick. The seconds counter advances on that tick while counting is enabled. At the all-ones value it either saturates or rolls over to zero, depending on a wrap control bit.

Software changes the time by writing a 32-bit load value and setting a load request bit in the control register. It reads the time by setting a snapshot request bit, which copies the live counter into a pair of snapshot registers as one coherent 32-bit value. The hardware drops both request bits once the transfer is done, so software polls them. A 32-bit match register drives an alarm. When the counter arrives at the match value, a pending flag is set. A mask, a force bit and a self-clearing clear bit control the interrupt output. An active-low soft-reset bit puts the time-keeping state back to zero and leaves the configuration registers alone.

Top module: `sec_rtc`

## Requirements
- R1: Registers are 16 bits wide and are addressed by byte offset. Accesses with bus_addr[1:0] not equal to 0 are ignored, and such reads return 0. The map is: 0x00 control, 0x04/0x08 rate low/high, 0x0C/0x10 load low/high, 0x14/0x18 match low/high, 0x1C status, 0x20/0x24 snapshot low/high. After a hardware reset, control reads 0x0021 and the rate registers hold the DEF_RATE parameter.
- R2: Control bit positions are 0 run (active low soft reset), 1 count enable, 2 wrap, 3 load request, 4 snapshot request, 5 mask, 6 force and 7 clear. With a rate word F ≥ 2, a second tick occurs every F clock cycles. A rate word of 0 or 1 gives a tick on every cycle. A load restarts the prescaler.
- R3: A control write with bit 3 set makes bit 3 read 1 for one cycle. At the next edge the counter takes the load value, and bit 3 then reads 0.
- R4: A control write with bit 4 set copies the counter value present in the following cycle into the snapshot registers at the next edge. Bit 4 then reads 0.
- R5: While count enable is 0, the counter does not change except through a load or a soft reset.
- R6: With wrap at 0, the counter holds at 0xFFFFFFFF. With wrap at 1, it rolls over to 0.
- R7: One cycle after the counter becomes equal to the match value, the pending flag is set. Status bit 0 reads pending OR force. Status bit 1 reads that value AND NOT mask.
- R8: While the mask is 1, irq stays 0 and status bit 0 still shows the pending alarm.
- R9: A control write with bit 7 set clears the pending flag at the next edge, unless a new match arrives in that same cycle. Bit 7 reads 0 afterwards.
- R10: With force at 1 and mask at 0, irq is 1 whether or not an alarm is pending.
- R11: While the run bit is 0, the counter, the prescaler, the pending flag and the request bits are held at 0. The rate, load and match registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
Properties are checked on every cycle for the following: the one-edge completion of the load and snapshot copies, the counter freezing while disabled, the saturation at all ones, the spacing between prescaler ticks, the hold in soft reset and the effect of the clear. Other results depend on end-to-end arithmetic and event order, and only the bench scenarios can show them. These are the exact count after a run of N cycles at a given rate word and wrap setting, the cycle in which an alarm becomes pending, how mask and force interact, and the survival of the configuration registers across a soft reset.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int unsigned BUS_W = 16;
  localparam int unsigned CNT_W = 2 * BUS_W;

  // word index = byte offset / 4
  localparam logic [3:0] IX_CTRL   = 4'd0;
  localparam logic [3:0] IX_RATE_L = 4'd1;
  localparam logic [3:0] IX_RATE_H = 4'd2;
  localparam logic [3:0] IX_LOAD_L = 4'd3;
  localparam logic [3:0] IX_LOAD_H = 4'd4;
  localparam logic [3:0] IX_MTCH_L = 4'd5;
  localparam logic [3:0] IX_MTCH_H = 4'd6;
  localparam logic [3:0] IX_STAT   = 4'd7;
  localparam logic [3:0] IX_SNAP_L = 4'd8;
  localparam logic [3:0] IX_SNAP_H = 4'd9;

  // control bit positions (software decodes these)
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_EN    = 1;
  localparam int unsigned CB_WRAP  = 2;
  localparam int unsigned CB_LOAD  = 3;
  localparam int unsigned CB_SNAP  = 4;
  localparam int unsigned CB_MASK  = 5;
  localparam int unsigned CB_FORCE = 6;
  localparam int unsigned CB_CLR   = 7;

  typedef struct packed {
    logic clr;
    logic force_on;
    logic mask;
    logic snap_req;
    logic load_req;
    logic wrap;
    logic en;
    logic run;
  } ctrl_t;

  // a tick is due when the divider reached rate-1 (rates 0 and 1 tick always)
  function automatic logic tick_due(input logic [CNT_W-1:0] pcnt,
                                    input logic [CNT_W-1:0] rate);
    return (rate <= 1) || (pcnt >= rate - 1);
  endfunction

  // next seconds value: saturate at all ones unless wrapping
  function automatic logic [CNT_W-1:0] next_secs(input logic [CNT_W-1:0] cur,
                                                 input logic wrap);
    if (&cur && !wrap) return cur;
    return cur + 1'b1;
  endfunction
endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
  import sec_rtc_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEF_RATE = 32'd32768,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  snap,
  input  logic              st_raw,
  input  logic              st_alarm,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  rate,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  match_val
);
  localparam int unsigned IX_W = ADDR_W - 2;

  logic            aligned;
  logic [IX_W-1:0] widx;
  logic            wr_ctrl;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_wr && aligned && (widx == IX_W'(IX_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{run: 1'b1, mask: 1'b1, default: 1'b0};
    end else if (wr_ctrl) begin
      ctrl.run      <= bus_wdata[CB_RUN];
      ctrl.en       <= bus_wdata[CB_EN];
      ctrl.wrap     <= bus_wdata[CB_WRAP];
      ctrl.mask     <= bus_wdata[CB_MASK];
      ctrl.force_on <= bus_wdata[CB_FORCE];
      ctrl.load_req <= bus_wdata[CB_LOAD] & bus_wdata[CB_RUN];
      ctrl.snap_req <= bus_wdata[CB_SNAP] & bus_wdata[CB_RUN];
      ctrl.clr      <= bus_wdata[CB_CLR]  & bus_wdata[CB_RUN];
    end else begin
      ctrl.load_req <= 1'b0;
      ctrl.snap_req <= 1'b0;
      ctrl.clr      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate      <= DEF_RATE;
      load_val  <= '0;
      match_val <= '0;
    end else if (bus_wr && aligned) begin
      case (widx)
        IX_W'(IX_RATE_L): rate[BUS_W-1:0]          <= bus_wdata;
        IX_W'(IX_RATE_H): rate[CNT_W-1:BUS_W]      <= bus_wdata;
        IX_W'(IX_LOAD_L): load_val[BUS_W-1:0]      <= bus_wdata;
        IX_W'(IX_LOAD_H): load_val[CNT_W-1:BUS_W]  <= bus_wdata;
        IX_W'(IX_MTCH_L): match_val[BUS_W-1:0]     <= bus_wdata;
        IX_W'(IX_MTCH_H): match_val[CNT_W-1:BUS_W] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        IX_W'(IX_CTRL):   bus_rdata = BUS_W'(ctrl);
        IX_W'(IX_RATE_L): bus_rdata = rate[BUS_W-1:0];
        IX_W'(IX_RATE_H): bus_rdata = rate[CNT_W-1:BUS_W];
        IX_W'(IX_LOAD_L): bus_rdata = load_val[BUS_W-1:0];
        IX_W'(IX_LOAD_H): bus_rdata = load_val[CNT_W-1:BUS_W];
        IX_W'(IX_MTCH_L): bus_rdata = match_val[BUS_W-1:0];
        IX_W'(IX_MTCH_H): bus_rdata = match_val[CNT_W-1:BUS_W];
        IX_W'(IX_STAT):   bus_rdata = BUS_W'({st_alarm, st_raw});
        IX_W'(IX_SNAP_L): bus_rdata = snap[BUS_W-1:0];
        IX_W'(IX_SNAP_H): bus_rdata = snap[CNT_W-1:BUS_W];
        default:          bus_rdata = '0;
      endcase
    end
  end

  AST_LOAD_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.load_req && !wr_ctrl) |=> !ctrl.load_req); // R3
  AST_CLR_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clr && !wr_ctrl) |=> !ctrl.clr); // R9
  AST_REQ_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !(ctrl.load_req || ctrl.snap_req || ctrl.clr)); // R11
endmodule

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale
  import sec_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] rate,
  output logic             tick
);
  logic [CNT_W-1:0] pcnt;

  assign tick = run && en && tick_due(pcnt, rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt <= '0;
    else if (!run || restart)   pcnt <= '0;
    else if (en)                pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate > 1) |=> (!tick || rate != $past(rate))); // R2
  AST_PRESCALE_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0)); // R11
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
  import sec_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             tick,
  input  logic             load_req,
  input  logic             snap_req,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] secs,
  output logic [CNT_W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs <= '0;
      snap <= '0;
    end else begin
      if (!run)          secs <= '0;
      else if (load_req) secs <= load_val;
      else if (tick)     secs <= next_secs(secs, wrap);
      if (snap_req)      snap <= secs;
    end
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && run) |=> (secs == $past(load_val))); // R3
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap == $past(secs))); // R4
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_req && !wrap && &secs) |=> &secs); // R6
  AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (secs == '0)); // R11
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm
  import sec_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] secs,
  input  logic [CNT_W-1:0] match_val,
  input  logic             mask,
  input  logic             force_on,
  input  logic             clr,
  output logic             st_raw,
  output logic             st_alarm
);
  logic eq_now;
  logic eq_prev;
  logic hit;
  logic pending;

  assign eq_now   = (secs == match_val);
  assign hit      = run && eq_now && !eq_prev;
  assign st_raw   = pending || force_on;
  assign st_alarm = st_raw && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_prev <= 1'b1;
      pending <= 1'b0;
    end else begin
      eq_prev <= eq_now;
      if (!run)      pending <= 1'b0;
      else if (hit)  pending <= 1'b1;
      else if (clr)  pending <= 1'b0;
    end
  end

  AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending); // R7
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !pending); // R9
  AST_PENDING_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pending); // R11
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter logic [31:0] DEF_RATE = 32'd32768,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] rate;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] match_val;
  logic [CNT_W-1:0] secs;
  logic [CNT_W-1:0] snap;
  logic             tick;
  logic             st_raw;
  logic             st_alarm;

  sec_rtc_regs #(.DEF_RATE(DEF_RATE), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snap(snap),
    .st_raw(st_raw), .st_alarm(st_alarm), .ctrl(ctrl), .rate(rate),
    .load_val(load_val), .match_val(match_val)
  );

  sec_rtc_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .en(ctrl.en),
    .restart(ctrl.load_req), .rate(rate), .tick(tick)
  );

  sec_rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .wrap(ctrl.wrap), .tick(tick),
    .load_req(ctrl.load_req), .snap_req(ctrl.snap_req), .load_val(load_val),
    .secs(secs), .snap(snap)
  );

  sec_rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .secs(secs),
    .match_val(match_val), .mask(ctrl.mask), .force_on(ctrl.force_on),
    .clr(ctrl.clr), .st_raw(st_raw), .st_alarm(st_alarm)
  );

  assign irq = st_alarm;

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.en && !ctrl.load_req) |=> $stable(secs)); // R5
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mask |-> !irq); // R8
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.force_on && !ctrl.mask) |-> irq); // R10
endmodule

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_RATE = 32'd32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_edge = 0;

  sec_rtc #(.DEF_RATE(DEF_RATE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // control word bits
  localparam logic [15:0] K_RUN = 16'h0001, K_EN = 16'h0002, K_WRAP = 16'h0004,
    K_LD = 16'h0008, K_SN = 16'h0010, K_MSK = 16'h0020, K_FRC = 16'h0040,
    K_CLR = 16'h0080;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    last_edge = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(a, lo); rd(a + 6'd4, hi); d = {hi, lo};
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    wr(a, d[15:0]); wr(a + 6'd4, d[31:16]);
  endtask

  task automatic upto(input int e);
    while (cyc < e) begin @(posedge clk); #1; end
  endtask

  // expected seconds after m cycles counted from a load
  function automatic logic [31:0] model_secs(input logic [31:0] ld, input logic [31:0] f,
                                             input int m, input logic wrp);
    longint unsigned per, sum;
    per = (f < 2) ? 1 : longint'(f);
    sum = longint'(ld) + longint'(m) / per;
    if (sum > 64'hFFFF_FFFF) return wrp ? sum[31:0] : 32'hFFFF_FFFF;
    return sum[31:0];
  endfunction

  // load, run for d cycles, snapshot; return snapshot and expected
  task automatic run_case(input logic [31:0] ld, input logic [31:0] f, input int d,
                          input logic wrp, output logic [31:0] got, output logic [31:0] exp);
    int w, r;
    logic [15:0] base;
    base = K_RUN | K_EN | K_MSK | (wrp ? K_WRAP : 16'h0);
    wr32(6'h04, f);
    wr32(6'h0C, ld);
    wr(6'h00, base | K_LD);
    w = last_edge;
    upto(w + d);
    wr(6'h00, base | K_SN);
    r = last_edge;
    upto(r + 1);
    rd32(6'h20, got);
    exp = model_secs(ld, f, r - (w + 1), wrp);
  endtask

  initial begin
    logic [15:0] v;
    logic [31:0] got, exp;
    int w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(6'h00, v); chk("R1 ctrl reset", 32'(v), 32'h0021);
    rd32(6'h04, got); chk("R1 rate reset", got, DEF_RATE);
    rd(6'h1C, v); chk("R1 status reset", 32'(v), 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // misaligned write ignored, read returns 0
    wr(6'h15, 16'hABCD);
    rd(6'h14, v); chk("R1 misaligned write ignored", 32'(v), 32'h0);
    rd(6'h15, v); chk("R1 misaligned read zero", 32'(v), 32'h0);

    // load request polling
    wr32(6'h0C, 32'h1234_5678);
    wr(6'h00, K_RUN | K_MSK | K_LD);
    rd(6'h00, v); chk("R3 load bit set", 32'(v[3]), 32'h1);
    upto(last_edge + 1);
    rd(6'h00, v); chk("R3 load bit cleared", 32'(v[3]), 32'h0);
    wr(6'h00, K_RUN | K_MSK | K_SN);
    rd(6'h00, v); chk("R4 snap bit set", 32'(v[4]), 32'h1);
    upto(last_edge + 1);
    rd(6'h00, v); chk("R4 snap bit cleared", 32'(v[4]), 32'h0);
    rd32(6'h20, got); chk("R3 loaded value", got, 32'h1234_5678);

    // count disabled: no change over time
    upto(cyc + 20);
    wr(6'h00, K_RUN | K_MSK | K_SN); upto(last_edge + 1);
    rd32(6'h20, got); chk("R5 frozen while disabled", got, 32'h1234_5678);

    // directed rate cases
    run_case(32'd10, 32'd0, 12, 1'b0, got, exp); chk("R2 rate 0", got, exp);
    run_case(32'd10, 32'd1, 9, 1'b0, got, exp); chk("R2 rate 1", got, exp);
    run_case(32'd0, 32'd7, 30, 1'b0, got, exp); chk("R2 rate 7", got, exp);
    run_case(32'hFFFF_FFFD, 32'd1, 10, 1'b0, got, exp); chk("R6 saturate", got, exp);
    run_case(32'hFFFF_FFFD, 32'd1, 10, 1'b1, got, exp); chk("R6 wrap", got, exp);

    // random cases
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ld, f;
      logic wrp;
      int d;
      ld  = ($urandom % 3 == 0) ? (32'hFFFF_FFF0 + ($urandom % 16)) : $urandom;
      f   = $urandom % 6;
      d   = $urandom % 30;
      wrp = $urandom % 2;
      run_case(ld, f, d, wrp, got, exp);
      chk(wrp ? "R6 R2 random wrap" : "R2 R6 random hold", got, exp);
    end

    // soft reset clears time, keeps configuration
    wr32(6'h04, 32'h0001_0003);
    wr32(6'h0C, 32'hCAFE_0042);
    wr32(6'h14, 32'h0BAD_F00D);
    wr(6'h00, 16'h0000);
    upto(last_edge + 2);
    wr(6'h00, K_RUN | K_MSK | K_SN); upto(last_edge + 1);
    rd32(6'h20, got); chk("R11 counter zeroed", got, 32'h0);
    rd32(6'h04, got); chk("R11 rate kept", got, 32'h0001_0003);
    rd32(6'h0C, got); chk("R11 load kept", got, 32'hCAFE_0042);
    rd32(6'h14, got); chk("R11 match kept", got, 32'h0BAD_F00D);
    wr(6'h00, K_LD | K_SN | K_CLR);
    rd(6'h00, v); chk("R11 requests dropped in soft reset", 32'(v), 32'h0);

    // alarm: rate 2, load 100, match 103
    wr32(6'h04, 32'd2);
    wr32(6'h0C, 32'd100);
    wr32(6'h14, 32'd103);
    wr(6'h00, K_RUN | K_EN | K_LD);
    w = last_edge;
    upto(w + 7); chk("R7 not yet pending", 32'(irq), 32'h0);
    upto(w + 8); chk("R7 irq on match", 32'(irq), 32'h1);
    rd(6'h1C, v); chk("R7 status both", 32'(v), 32'h3);
    wr(6'h00, K_RUN | K_EN | K_MSK);
    chk("R8 masked irq low", 32'(irq), 32'h0);
    rd(6'h1C, v); chk("R8 raw still set", 32'(v), 32'h1);
    wr(6'h00, K_RUN | K_EN | K_CLR);
    upto(last_edge + 1);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    rd(6'h1C, v); chk("R9 status cleared", 32'(v), 32'h0);
    rd(6'h00, v); chk("R9 clear bit self-clears", 32'(v[7]), 32'h0);
    wr(6'h00, K_RUN | K_EN | K_FRC);
    chk("R10 force raises irq", 32'(irq), 32'h1);
    rd(6'h1C, v); chk("R10 force status", 32'(v), 32'h3);
    wr(6'h00, K_RUN | K_EN);
    chk("R10 force released", 32'(irq), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule